// File: doc/BRIEF.md
# Registered DIMM Power-Up Sequencer

This block sits on the controller side of a registered DDR memory module. It walks the module from power-on to the point where the ordinary SDRAM initialisation engine can take over. While the supplies and clocks settle, it keeps the module's active-low register reset asserted. That reset forces every register output, clock enables included, to a low level. The block then waits for the PLL to lock and for the SDRAM clock to settle. Next it releases the register reset. The command bus stays frozen and CKE stays low for a register activation time. Finally it emits a one-cycle start pulse for the downstream init engine and raises a level that stays high while the module is usable.

All delays are counted in clock cycles by one shared down-counter. Each microsecond figure is multiplied by a cycles-per-microsecond parameter. Once the sequence is complete, the block passes the downstream engine's command bus and clock enable through one register stage to the module pins. A single host clock-enable bit drives every rank's CKE together. This is required because one reset governs all register devices. For deep power saving, the controller can park the module after self-refresh entry. Parking asserts the register reset again. Waking from park repeats only the PLL wait and the activation wait, and does not emit the start pulse, so the downstream engine does not re-initialise the memory.

Top module: `rdimm_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until the release point, `reg_rst_n` is 0, every `cke` bit is 0, and `init_start` and `init_ready` are 0.
- R2: Whenever `init_ready` is 0, the command pins carry the idle pattern. With `IDLE_DESELECT`=1 the pattern is: all `cs_n` bits 1; `ras_n`, `cas_n` and `we_n` 1; `addr` and `ba` 0. With `IDLE_DESELECT`=0, every command pin is 0.
- R3: Cold start. Let k be the clock edge that first samples `pwr_good`=1 and `clk_ok`=1 in the hold state. `reg_rst_n` rises on edge k + N1 + N2, where N1 = CLK_WAIT_US×CYCLES_PER_US and N2 = SDRAM_WAIT_US×CYCLES_PER_US.
- R4: If `clk_ok` falls during the PLL wait or the SDRAM wait, the block returns to the hold state with `reg_rst_n` low. It restarts the full cold timing of R3 once `clk_ok` returns.
- R5: After `reg_rst_n` rises, `cke` stays 0 and the command pins stay idle for 1 + T_ACT_CYCLES cycles. On the next edge, `init_ready` rises and `init_start` is high for exactly that one cycle.
- R6: While `init_ready` is 1, the pins follow the host inputs with one cycle of latency, and `h_cke` drives every `cke` bit.
- R7: If `pwr_good` is 0 at an edge in any state, then after that edge `reg_rst_n`, `cke`, `init_ready` and `init_start` are 0. The next start uses the cold timing of R3.
- R8: If `sr_park` is 1 while ready, `reg_rst_n`, `cke` and `init_ready` go to 0 on the next edge. `sr_park` has no effect before the block is ready.
- R9: The block leaves park when `sr_park` is 0 and `clk_ok` is 1, and not before. `reg_rst_n` then rises N1 + 1 edges later and `init_ready` 1 + T_ACT_CYCLES edges after that. No `init_start` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Supplies are within range |
| clk_ok | input | 1 | Module clock is running and stable |
| sr_park | input | 1 | Request to park the module registers (after self-refresh entry) |
| h_cke | input | 1 | Clock enable from the downstream engine |
| h_cs_n | input | RANKS | Chip selects from the downstream engine |
| h_ras_n | input | 1 | Row strobe from the downstream engine |
| h_cas_n | input | 1 | Column strobe from the downstream engine |
| h_we_n | input | 1 | Write enable from the downstream engine |
| h_addr | input | ADDR_W | Address from the downstream engine |
| h_ba | input | BA_W | Bank address from the downstream engine |
| reg_rst_n | output | 1 | Active-low reset to the module register devices |
| cke | output | RANKS | Clock enables, driven together |
| cs_n | output | RANKS | Chip selects to the module |
| ras_n | output | 1 | Row strobe to the module |
| cas_n | output | 1 | Column strobe to the module |
| we_n | output | 1 | Write enable to the module |
| addr | output | ADDR_W | Address to the module |
| ba | output | BA_W | Bank address to the module |
| init_start | output | 1 | One-cycle pulse that starts SDRAM initialisation |
| init_ready | output | 1 | High while the module is handed over |

## Verification
The bench measures the exact number of edges to the reset release and to the ready point, on the cold path and on the wake path. A counter loaded off by one, or a wake that wrongly repeats the SDRAM wait, shows up as a wrong count. It drops `clk_ok` and `pwr_good` at random points in the sequence. A design that kept its count, or that left the warm flag set, would release reset too early. It toggles `sr_park` before the block is ready, where a design that honoured it would park or stall. It also holds `clk_ok` low while un-parking, which catches a wake that ignores the clock state. Random and all-ones/all-zeros host vectors check the one-cycle pass-through and the tying of the CKE bits. A design that leaked host values before ready, or split the enables, would miscompare.

// File: rtl/rdimm_seq_pkg.sv
package rdimm_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_PLL     = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_ACT     = 3'd4,
    ST_READY   = 3'd5,
    ST_PARK    = 3'd6
  } seq_state_e;

  // Cycles spent in a microsecond-based wait
  function automatic int us_to_cycles(input int us, input int cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Value loaded into the down-counter on entry to a timed state
  function automatic int entry_load(input seq_state_e st, input int n_pll,
                                    input int n_settle, input int n_act);
    case (st)
      ST_PLL:    return n_pll - 1;
      ST_SETTLE: return n_settle - 1;
      ST_ACT:    return n_act - 1;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/seq_down_counter.sv
module seq_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R3

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import rdimm_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int N_PLL    = 4,
  parameter int N_SETTLE = 8,
  parameter int N_ACT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             clk_ok,
  input  logic             sr_park,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             cold_start
);

  logic warm_q;
  logic enter_ready_w;
  logic enter_park_w;

  always_comb begin
    state_d = state_q;
    if (!pwr_good) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_HOLD:    if (clk_ok) state_d = ST_PLL;
        ST_PLL: begin
          if (!clk_ok)       state_d = ST_HOLD;
          else if (cnt_zero) state_d = warm_q ? ST_RELEASE : ST_SETTLE;
        end
        ST_SETTLE: begin
          if (!clk_ok)       state_d = ST_HOLD;
          else if (cnt_zero) state_d = ST_RELEASE;
        end
        ST_RELEASE: state_d = ST_ACT;
        ST_ACT:     if (cnt_zero) state_d = ST_READY;
        ST_READY:   if (sr_park) state_d = ST_PARK;
        ST_PARK:    if (!sr_park && clk_ok) state_d = ST_PLL;
        default:    state_d = ST_HOLD;
      endcase
    end
  end

  assign enter_ready_w = (state_d == ST_READY) && (state_q != ST_READY);
  assign enter_park_w  = (state_d == ST_PARK) && (state_q != ST_PARK);
  assign cold_start    = enter_ready_w && !warm_q;
  assign cnt_load      = (state_d != state_q);
  assign cnt_load_val  = CNT_W'(entry_load(state_d, N_PLL, N_SETTLE, N_ACT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!pwr_good)          warm_q <= 1'b0;
      else if (enter_park_w)  warm_q <= 1'b1;
      else if (enter_ready_w) warm_q <= 1'b0;
    end
  end

  AST_PGOOD_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state_q == ST_HOLD)); // R7

  AST_ACT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT && $past(state_q) != ST_ACT) |-> $past(state_q) == ST_RELEASE); // R5

  AST_PARK_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK && !clk_ok && pwr_good) |=> (state_q == ST_PARK)); // R9

endmodule

// File: rtl/seq_pin_drive.sv
module seq_pin_drive
  import rdimm_seq_pkg::*;
#(
  parameter int RANKS         = 2,
  parameter int ADDR_W        = 14,
  parameter int BA_W          = 2,
  parameter bit IDLE_DESELECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              cold_start,
  input  logic              h_cke,
  input  logic [RANKS-1:0]  h_cs_n,
  input  logic              h_ras_n,
  input  logic              h_cas_n,
  input  logic              h_we_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [BA_W-1:0]   h_ba,
  output logic              reg_rst_n,
  output logic [RANKS-1:0]  cke,
  output logic [RANKS-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_start,
  output logic              init_ready
);

  logic [RANKS-1:0] idle_cs_n;
  logic             idle_strobe;
  logic             release_w;
  logic             handed_w;

  generate
    if (IDLE_DESELECT) begin : g_deselect
      assign idle_cs_n   = '1;
      assign idle_strobe = 1'b1;
    end else begin : g_all_zero
      assign idle_cs_n   = '0;
      assign idle_strobe = 1'b0;
    end
  endgenerate

  assign release_w = (state_d == ST_RELEASE) || (state_d == ST_ACT) || (state_d == ST_READY);
  assign handed_w  = (state_d == ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rst_n  <= 1'b0;
      cke        <= '0;
      cs_n       <= idle_cs_n;
      ras_n      <= idle_strobe;
      cas_n      <= idle_strobe;
      we_n       <= idle_strobe;
      addr       <= '0;
      ba         <= '0;
      init_start <= 1'b0;
      init_ready <= 1'b0;
    end else begin
      reg_rst_n  <= release_w;
      init_ready <= handed_w;
      init_start <= cold_start;
      if (handed_w) begin
        cke   <= {RANKS{h_cke}};
        cs_n  <= h_cs_n;
        ras_n <= h_ras_n;
        cas_n <= h_cas_n;
        we_n  <= h_we_n;
        addr  <= h_addr;
        ba    <= h_ba;
      end else begin
        cke   <= '0;
        cs_n  <= idle_cs_n;
        ras_n <= idle_strobe;
        cas_n <= idle_strobe;
        we_n  <= idle_strobe;
        addr  <= '0;
        ba    <= '0;
      end
    end
  end

  AST_CKE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rst_n |-> (cke == '0)); // R1

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start); // R5

  AST_START_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> init_ready); // R5

  AST_IDLE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ready |-> (cs_n == idle_cs_n && addr == '0 && ba == '0)); // R2

endmodule

// File: rtl/rdimm_pwrup_seq.sv
module rdimm_pwrup_seq
  import rdimm_seq_pkg::*;
#(
  parameter int CYCLES_PER_US     = 200,
  parameter int MAX_CYCLES_PER_US = 1000,
  parameter int CLK_WAIT_US       = 100,
  parameter int SDRAM_WAIT_US     = 200,
  parameter int T_ACT_CYCLES      = 16,
  parameter int RANKS             = 2,
  parameter int ADDR_W            = 14,
  parameter int BA_W              = 2,
  parameter bit IDLE_DESELECT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              clk_ok,
  input  logic              sr_park,
  input  logic              h_cke,
  input  logic [RANKS-1:0]  h_cs_n,
  input  logic              h_ras_n,
  input  logic              h_cas_n,
  input  logic              h_we_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [BA_W-1:0]   h_ba,
  output logic              reg_rst_n,
  output logic [RANKS-1:0]  cke,
  output logic [RANKS-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_start,
  output logic              init_ready
);

  localparam int N_PLL    = us_to_cycles(CLK_WAIT_US, CYCLES_PER_US);
  localparam int N_SETTLE = us_to_cycles(SDRAM_WAIT_US, CYCLES_PER_US);
  localparam int LONGEST  = max3(us_to_cycles(CLK_WAIT_US, MAX_CYCLES_PER_US),
                                 us_to_cycles(SDRAM_WAIT_US, MAX_CYCLES_PER_US),
                                 T_ACT_CYCLES);
  localparam int CNT_W    = $clog2(LONGEST + 1);

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             cnt_zero;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cold_start;

  seq_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .zero     (cnt_zero)
  );

  seq_fsm #(
    .CNT_W    (CNT_W),
    .N_PLL    (N_PLL),
    .N_SETTLE (N_SETTLE),
    .N_ACT    (T_ACT_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .clk_ok       (clk_ok),
    .sr_park      (sr_park),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .state_q      (state_q),
    .state_d      (state_d),
    .cold_start   (cold_start)
  );

  seq_pin_drive #(
    .RANKS         (RANKS),
    .ADDR_W        (ADDR_W),
    .BA_W          (BA_W),
    .IDLE_DESELECT (IDLE_DESELECT)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .cold_start (cold_start),
    .h_cke      (h_cke),
    .h_cs_n     (h_cs_n),
    .h_ras_n    (h_ras_n),
    .h_cas_n    (h_cas_n),
    .h_we_n     (h_we_n),
    .h_addr     (h_addr),
    .h_ba       (h_ba),
    .reg_rst_n  (reg_rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .ba         (ba),
    .init_start (init_start),
    .init_ready (init_ready)
  );

  AST_BUS_FROZEN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT) |-> ($stable({cs_n, ras_n, cas_n, we_n, addr, ba}) && cke == '0)); // R5

  AST_RST_RISE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rst_n) |-> (state_q == ST_RELEASE)); // R3

  AST_PARK_DROPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && sr_park && pwr_good) |=> (!reg_rst_n && !init_ready)); // R8

  AST_PGOOD_LOSS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!reg_rst_n && !init_ready && cke == '0)); // R7

endmodule

// File: tb/sim_rdimm_pwrup_seq.sv
`timescale 1ns/1ps
module sim_rdimm_pwrup_seq;

  localparam int CPU   = 2;
  localparam int C_US  = 100;
  localparam int S_US  = 200;
  localparam int TACT  = 8;
  localparam int RANKS = 2;
  localparam int AW    = 14;
  localparam int BW    = 2;

  logic clk = 1'b0;
  logic rst_n, pwr_good, clk_ok, sr_park;
  logic h_cke, h_ras_n, h_cas_n, h_we_n;
  logic [RANKS-1:0] h_cs_n;
  logic [AW-1:0] h_addr;
  logic [BW-1:0] h_ba;

  logic reg_rst_n, ras_n, cas_n, we_n, init_start, init_ready;
  logic [RANKS-1:0] cke, cs_n;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;

  logic reg_rst_n1, ras_n1, cas_n1, we_n1, init_start1, init_ready1;
  logic [RANKS-1:0] cke1, cs_n1;
  logic [AW-1:0] addr1;
  logic [BW-1:0] ba1;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  rdimm_pwrup_seq #(.CYCLES_PER_US(CPU), .MAX_CYCLES_PER_US(8), .CLK_WAIT_US(C_US),
    .SDRAM_WAIT_US(S_US), .T_ACT_CYCLES(TACT), .RANKS(RANKS), .ADDR_W(AW), .BA_W(BW),
    .IDLE_DESELECT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_ok(clk_ok), .sr_park(sr_park),
    .h_cke(h_cke), .h_cs_n(h_cs_n), .h_ras_n(h_ras_n), .h_cas_n(h_cas_n), .h_we_n(h_we_n),
    .h_addr(h_addr), .h_ba(h_ba), .reg_rst_n(reg_rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .init_start(init_start), .init_ready(init_ready));

  rdimm_pwrup_seq #(.CYCLES_PER_US(CPU), .MAX_CYCLES_PER_US(8), .CLK_WAIT_US(C_US),
    .SDRAM_WAIT_US(S_US), .T_ACT_CYCLES(TACT), .RANKS(RANKS), .ADDR_W(AW), .BA_W(BW),
    .IDLE_DESELECT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_ok(clk_ok), .sr_park(sr_park),
    .h_cke(h_cke), .h_cs_n(h_cs_n), .h_ras_n(h_ras_n), .h_cas_n(h_cas_n), .h_we_n(h_we_n),
    .h_addr(h_addr), .h_ba(h_ba), .reg_rst_n(reg_rst_n1), .cke(cke1), .cs_n(cs_n1),
    .ras_n(ras_n1), .cas_n(cas_n1), .we_n(we_n1), .addr(addr1), .ba(ba1),
    .init_start(init_start1), .init_ready(init_ready1));

  // Expected edge counts, restated from the requirements
  function automatic int cold_rise();
    return C_US * CPU + S_US * CPU + 1;
  endfunction
  function automatic int warm_rise();
    return C_US * CPU + 1;
  endfunction
  function automatic int act_span();
    return TACT + 1;
  endfunction

  function automatic bit idle0();
    return cke == 2'b00 && cs_n == 2'b11 && ras_n && cas_n && we_n && addr == '0 && ba == '0;
  endfunction
  function automatic bit idle1();
    return cke1 == 2'b00 && cs_n1 == 2'b00 && !ras_n1 && !cas_n1 && !we_n1
           && addr1 == '0 && ba1 == '0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic wait_rise(input bit noise, output int k, output bit hold_ok);
    k = 0;
    hold_ok = 1'b1;
    while (!reg_rst_n && k < 4000) begin
      sr_park = (noise && k < 10) ? 1'($urandom % 2) : 1'b0;
      step();
      k++;
      if (!(idle0() && idle1() && !init_ready && !init_start)) hold_ok = 1'b0;
    end
    sr_park = 1'b0;
  endtask

  task automatic wait_ready(output int k, output bit saw_start, output bit hold_ok);
    k = 0;
    saw_start = 1'b0;
    hold_ok = 1'b1;
    while (!init_ready && k < 4000) begin
      step();
      k++;
      if (init_start) saw_start = 1'b1;
      if (!init_ready && !(idle0() && idle1() && reg_rst_n)) hold_ok = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: every requirement unreached actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int k;
    bit ok;
    bit st;
    logic [22:0] expv;
    logic [22:0] actv;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; pwr_good = 1'b0; clk_ok = 1'b0; sr_park = 1'b0;
    h_cke = 1'b0; h_cs_n = '1; h_ras_n = 1'b1; h_cas_n = 1'b1; h_we_n = 1'b1;
    h_addr = '0; h_ba = '0;
    repeat (4) step();
    // R1 and R2: reset state of both idle variants
    chk(!reg_rst_n && !init_start && !init_ready, "R1 reset pins", reg_rst_n, 0);
    chk(idle0(), "R2 deselect idle in reset", cs_n, 3);
    chk(idle1(), "R2 all-zero idle in reset", cs_n1, 0);
    rst_n = 1'b1;
    pwr_good = 1'b1;
    repeat (12) step();
    chk(!reg_rst_n && idle0() && idle1() && !init_ready, "R1 hold without clock", reg_rst_n, 0);

    // R3 cold timing, with R8 park noise before ready
    clk_ok = 1'b1;
    wait_rise(1'b1, k, ok);
    chk(k == cold_rise(), "R3 cold release edge (R8 noise ignored)", k, cold_rise());
    chk(ok, "R1 hold pins during waits", ok, 1);
    wait_ready(k, st, ok);
    chk(k == act_span(), "R5 activation span", k, act_span());
    chk(st && init_start, "R5 start pulse at ready", st, 1);
    chk(ok, "R5 bus frozen during activation", ok, 1);
    step();
    chk(!init_start && init_ready, "R5 start lasts one cycle", init_start, 0);

    // R6 pass-through: directed extremes then random
    for (int i = 0; i < 42; i++) begin
      if (i == 0) begin
        h_cke = 1'b1; h_cs_n = '1; h_ras_n = 1'b1; h_cas_n = 1'b1; h_we_n = 1'b1;
        h_addr = '1; h_ba = '1;
      end else if (i == 1) begin
        h_cke = 1'b0; h_cs_n = '0; h_ras_n = 1'b0; h_cas_n = 1'b0; h_we_n = 1'b0;
        h_addr = '0; h_ba = '0;
      end else begin
        h_cke = 1'($urandom); h_cs_n = 2'($urandom); h_ras_n = 1'($urandom);
        h_cas_n = 1'($urandom); h_we_n = 1'($urandom); h_addr = 14'($urandom);
        h_ba = 2'($urandom);
      end
      expv = {h_cke, h_cke, h_cs_n, h_ras_n, h_cas_n, h_we_n, h_addr, h_ba};
      step();
      actv = {cke, cs_n, ras_n, cas_n, we_n, addr, ba};
      chk(actv == expv && init_ready, "R6 host pass-through", actv, expv);
    end

    // R8 park, then R9 wake
    h_cke = 1'b1;
    sr_park = 1'b1;
    step();
    chk(!reg_rst_n && cke == 2'b00 && !init_ready && idle0(), "R8 park drops reset",
        {reg_rst_n, cke, init_ready}, 0);
    clk_ok = 1'b0;
    sr_park = 1'b0;
    repeat (6) step();
    chk(!reg_rst_n && !init_ready, "R9 park held while clock stopped", reg_rst_n, 0);
    clk_ok = 1'b1;
    wait_rise(1'b0, k, ok);
    chk(k == warm_rise(), "R9 wake release edge", k, warm_rise());
    wait_ready(k, st, ok);
    chk(k == act_span(), "R9 wake activation span", k, act_span());
    chk(!st, "R9 no start pulse on wake", st, 0);

    // R4 clock loss during waits restarts cold timing
    for (int it = 0; it < 3; it++) begin
      pwr_good = 1'b0;
      step();
      chk(!reg_rst_n && !init_ready && cke == 2'b00, "R7 drop from ready", reg_rst_n, 0);
      pwr_good = 1'b1;
      repeat (5 + ($urandom % (cold_rise() - 10))) step();
      clk_ok = 1'b0;
      repeat (2) step();
      chk(!reg_rst_n, "R4 reset low after clock loss", reg_rst_n, 0);
      clk_ok = 1'b1;
      wait_rise(1'b0, k, ok);
      chk(k == cold_rise(), "R4 restart uses cold timing", k, cold_rise());
      wait_ready(k, st, ok);
      chk(st, "R4 start after restart", st, 1);
    end

    // R7 power loss at random points, including the wake path
    for (int it = 0; it < 6; it++) begin
      if (it == 5) begin
        sr_park = 1'b1;
        step();
        sr_park = 1'b0;
        repeat (20) step();
      end else begin
        pwr_good = 1'b0;
        step();
        pwr_good = 1'b1;
        repeat ($urandom % (cold_rise() + TACT + 4)) step();
      end
      pwr_good = 1'b0;
      step();
      chk(!reg_rst_n && !init_ready && !init_start && idle0() && idle1(), "R7 pins after loss",
          {reg_rst_n, init_ready, init_start}, 0);
      pwr_good = 1'b1;
      wait_rise(1'b0, k, ok);
      chk(k == cold_rise(), "R7 cold timing after loss", k, cold_rise());
      wait_ready(k, st, ok);
      chk(st, "R7 start after loss", st, 1);
    end

    summary();
    $finish;
  end

endmodule